// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Unit

This block is the external-interrupt facility of a 32-bit processor with a stepped control unit. In the first control step of every instruction fetch it compares the incoming request with a single enable flag. When it accepts a request, it keeps the current program counter and a 16-bit cause word from the device in two dedicated registers. It clears the enable flag and redirects the program counter to a vector built from an 8-bit device type code. For the length of that step it raises an acknowledge to the device.

The instruction decoder presents the interrupt-related instructions through an operation strobe and an opcode. These are return-from-interrupt, enable, disable, save-state and restore-state. The unit performs them directly. There are no priority levels, and any arbitration between several devices happens outside the block. The request, cause word and type code come from the device as plain level signals, not as a valid/ready stream. The device holds them until it sees the acknowledge, which lasts exactly one step. The save-state result is a one-cycle strobe with no back-pressure, and it is consumed by the register-file write in the same step.

Top module: `irq_entry_unit`

## Requirements
- R1: An interrupt is accepted (`irq_ack` high, `pc_load` high) only in a cycle where `fetch_t0`, `irq_req` and the enable flag are all 1 and `op_valid` is 0; in any other cycle `irq_ack` is 0.
- R2: On acceptance, `cur_pc` is stored as the saved PC and `irq_info` as the saved cause word, visible on `saved_pc` and `saved_info` from the next cycle.
- R3: On acceptance, the enable flag (`irq_en`) is 0 from the next cycle.
- R4: On acceptance, `pc_next` equals the type code placed at bits 11..4 with every other bit 0.
- R5: `irq_ack` is a single-cycle pulse: it is 0 in the cycle after acceptance.
- R6: Opcode 29 with `op_valid` drives `pc_load`=1 and `pc_next`=saved PC in that cycle, and sets `irq_en` from the next cycle.
- R7: Opcode 10 with `op_valid` sets `irq_en`; opcode 11 with `op_valid` clears it, both from the next cycle.
- R8: Opcode 16 with `op_valid` raises `save_valid` in that cycle, while `saved_info` and `saved_pc` carry the saved cause word and saved PC.
- R9: Opcode 17 with `op_valid` loads the saved cause word from `reg_a[15:0]` and the saved PC from `reg_b`, effective from the next cycle.
- R10: After reset, `irq_en` is 0, the saved PC and the saved cause word are 0, and `pc_load`, `irq_ack` and `save_valid` are 0 when idle.
- R11: An operation strobe in the same cycle as a fetch-start request takes precedence. This includes a return with the enable already set. The request is then accepted at the next fetch start without a strobe.
- R12: Any other opcode with `op_valid` changes no state and drives `pc_load` and `save_valid` to 0; `pc_next` is 0 whenever `pc_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| fetch_t0 | input | 1 | High in the first control step of instruction fetch |
| cur_pc | input | 32 | Current program counter |
| irq_req | input | 1 | External interrupt request |
| irq_info | input | 16 | Cause word from the device |
| irq_code | input | 8 | Device type code used to form the vector |
| op_valid | input | 1 | Decoder presents an interrupt-related operation |
| op_code | input | 5 | Opcode of that operation |
| reg_a | input | 32 | Register value for the restored cause word (low 16 bits) |
| reg_b | input | 32 | Register value for the restored saved PC |
| pc_load | output | 1 | Program counter must take `pc_next` this step |
| pc_next | output | 32 | New program counter value |
| irq_ack | output | 1 | Acknowledge to the device |
| irq_en | output | 1 | Current enable flag |
| save_valid | output | 1 | Save-state result is valid for a register write |
| saved_info | output | 16 | Saved cause word |
| saved_pc | output | 32 | Saved program counter |

## Verification
The hardest case to reach is a fetch-start request that arrives while the enable flag is already set and an operation strobe is present in the same cycle, above all a return whose effect would re-enable interrupts. To get there, the stimulus first enables the unit, then takes an interrupt, re-enables it through a return and presents a return together with a fetch-start request. It then checks that the return wins and that the pending request is accepted at the following fetch start. Restored state is read back through the save operation, so every stored value is observed at the ports.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  typedef enum logic [2:0] {
    IOP_NONE    = 3'd0,
    IOP_RETURN  = 3'd1,
    IOP_ENABLE  = 3'd2,
    IOP_DISABLE = 3'd3,
    IOP_SAVE    = 3'd4,
    IOP_RESTORE = 3'd5
  } irq_op_e;
endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_unit_pkg::*;
#(
  parameter int OPC_W      = 5,
  parameter int OP_RETURN  = 29,
  parameter int OP_ENABLE  = 10,
  parameter int OP_DISABLE = 11,
  parameter int OP_SAVE    = 16,
  parameter int OP_RESTORE = 17
) (
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output irq_op_e          op_kind
);
  always_comb begin
    op_kind = IOP_NONE;
    if (op_valid) begin
      if      (op_code == OPC_W'(OP_RETURN))  op_kind = IOP_RETURN;
      else if (op_code == OPC_W'(OP_ENABLE))  op_kind = IOP_ENABLE;
      else if (op_code == OPC_W'(OP_DISABLE)) op_kind = IOP_DISABLE;
      else if (op_code == OPC_W'(OP_SAVE))    op_kind = IOP_SAVE;
      else if (op_code == OPC_W'(OP_RESTORE)) op_kind = IOP_RESTORE;
      else                                    op_kind = IOP_NONE;
    end
  end
endmodule

// File: rtl/irq_enable_flag.sv
module irq_enable_flag
  import irq_unit_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  irq_op_e op_kind,
  output logic    en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     en_q <= 1'b0;
    else if (take)                  en_q <= 1'b0;
    else if (op_kind == IOP_RETURN) en_q <= 1'b1;
    else if (op_kind == IOP_ENABLE) en_q <= 1'b1;
    else if (op_kind == IOP_DISABLE) en_q <= 1'b0;
  end

  // R3: acceptance leaves interrupts disabled
  assert_entry_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !en_q);
  // R6: return re-enables
  assert_return_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == IOP_RETURN && !take) |=> en_q);
  // R7: disable clears
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == IOP_DISABLE && !take) |=> !en_q);
  // R12: no operation and no acceptance keeps the flag
  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == IOP_NONE && !take) |=> $stable(en_q));
endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs
  import irq_unit_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int INFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  irq_op_e           op_kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [INFO_W-1:0] dev_info,
  input  logic [XLEN-1:0]   src_info_reg,
  input  logic [XLEN-1:0]   src_pc_reg,
  output logic [XLEN-1:0]   spc_q,
  output logic [INFO_W-1:0] sinfo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spc_q   <= '0;
      sinfo_q <= '0;
    end else if (take) begin
      spc_q   <= cur_pc;
      sinfo_q <= dev_info;
    end else if (op_kind == IOP_RESTORE) begin
      spc_q   <= src_pc_reg;
      sinfo_q <= src_info_reg[INFO_W-1:0];
    end
  end

  // R9: restore loads from the register values
  assert_restore_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == IOP_RESTORE && !take) |=> spc_q == $past(src_pc_reg));
  assert_restore_info_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == IOP_RESTORE && !take) |=> sinfo_q == $past(src_info_reg[INFO_W-1:0]));
  // R12: without acceptance or restore the saved state holds
  assert_state_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && op_kind != IOP_RESTORE) |=> ($stable(spc_q) && $stable(sinfo_q)));
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_unit_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CODE_W  = 8,
  parameter int VEC_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  irq_op_e           op_kind,
  input  logic [CODE_W-1:0] dev_code,
  input  logic [XLEN-1:0]   spc_q,
  output logic              pc_load,
  output logic [XLEN-1:0]   pc_next
);
  localparam int HI_W = XLEN - CODE_W - VEC_LSB;

  logic [XLEN-1:0] vec_addr;

  generate
    if (VEC_LSB > 0) begin : g_low_pad
      assign vec_addr = {{HI_W{1'b0}}, dev_code, {VEC_LSB{1'b0}}};
    end else begin : g_no_pad
      assign vec_addr = {{HI_W{1'b0}}, dev_code};
    end
  endgenerate

  always_comb begin
    pc_load = 1'b0;
    pc_next = '0;
    if (take) begin
      pc_load = 1'b1;
      pc_next = vec_addr;
    end else if (op_kind == IOP_RETURN) begin
      pc_load = 1'b1;
      pc_next = spc_q;
    end
  end

  // R4: vector has nothing above the code field
  assert_vec_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pc_load && (pc_next >> (CODE_W + VEC_LSB)) == '0));
  // R12: no load means a zero target
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |-> pc_next == '0);
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_unit_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int INFO_W  = 16,
  parameter int CODE_W  = 8,
  parameter int VEC_LSB = 4,
  parameter int OPC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_t0,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              irq_req,
  input  logic [INFO_W-1:0] irq_info,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [XLEN-1:0]   reg_a,
  input  logic [XLEN-1:0]   reg_b,
  output logic              pc_load,
  output logic [XLEN-1:0]   pc_next,
  output logic              irq_ack,
  output logic              irq_en,
  output logic              save_valid,
  output logic [INFO_W-1:0] saved_info,
  output logic [XLEN-1:0]   saved_pc
);
  irq_op_e kind;
  logic    take;
  logic    en_q;

  irq_op_decode #(.OPC_W(OPC_W)) u_dec (
    .op_valid(op_valid), .op_code(op_code), .op_kind(kind)
  );

  // operation strobe has precedence over a request in the same cycle
  assign take = fetch_t0 & irq_req & en_q & ~op_valid;

  irq_enable_flag u_en (
    .clk(clk), .rst_n(rst_n), .take(take), .op_kind(kind), .en_q(en_q)
  );

  irq_save_regs #(.XLEN(XLEN), .INFO_W(INFO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .take(take), .op_kind(kind),
    .cur_pc(cur_pc), .dev_info(irq_info),
    .src_info_reg(reg_a), .src_pc_reg(reg_b),
    .spc_q(saved_pc), .sinfo_q(saved_info)
  );

  irq_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_LSB(VEC_LSB)) u_vec (
    .clk(clk), .rst_n(rst_n), .take(take), .op_kind(kind),
    .dev_code(irq_code), .spc_q(saved_pc),
    .pc_load(pc_load), .pc_next(pc_next)
  );

  assign irq_ack    = take;
  assign irq_en     = en_q;
  assign save_valid = (kind == IOP_SAVE);

  // R1: acknowledge needs enable, fetch start and a request
  assert_ack_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_en && fetch_t0 && irq_req));
  // R11: acknowledge never coincides with an operation strobe
  assert_op_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !op_valid);
  // R5: single-step acknowledge pulse
  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  // R2: PC and cause word captured on acceptance
  assert_pc_saved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (saved_pc == $past(cur_pc) && saved_info == $past(irq_info)));
  // R8: save strobe only for an operation
  assert_save_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> (op_valid && !pc_load));
endmodule

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;
  localparam int CLK_P = 10;

  typedef struct {
    string       tag;
    logic        pc_load;
    logic [31:0] pc_next;
    logic        ack;
    logic        en;
    logic        save_valid;
    logic [15:0] sinfo;
    logic [31:0] spc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_t0 = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        irq_req = 1'b0;
  logic [15:0] irq_info = '0;
  logic [7:0]  irq_code = '0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] reg_a = '0;
  logic [31:0] reg_b = '0;
  logic        pc_load, irq_ack, irq_en, save_valid;
  logic [31:0] pc_next, saved_pc;
  logic [15:0] saved_info;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  // bench model state
  bit          m_en = 1'b0;
  logic [31:0] m_spc = '0;
  logic [15:0] m_sinfo = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_unit u_irq_entry_unit (
    .clk(clk), .rst_n(rst_n), .fetch_t0(fetch_t0), .cur_pc(cur_pc),
    .irq_req(irq_req), .irq_info(irq_info), .irq_code(irq_code),
    .op_valid(op_valid), .op_code(op_code), .reg_a(reg_a), .reg_b(reg_b),
    .pc_load(pc_load), .pc_next(pc_next), .irq_ack(irq_ack), .irq_en(irq_en),
    .save_valid(save_valid), .saved_info(saved_info), .saved_pc(saved_pc)
  );

  task automatic drive(string tag, bit t0, bit req, logic [31:0] pc,
                       logic [7:0] code, logic [15:0] info, bit opv,
                       logic [4:0] op, logic [31:0] ra, logic [31:0] rb);
    exp_t e;
    bit   acc;
    @(negedge clk);
    #1;
    fetch_t0 = t0; irq_req = req; cur_pc = pc; irq_code = code;
    irq_info = info; op_valid = opv; op_code = op; reg_a = ra; reg_b = rb;
    acc = t0 && req && m_en && !opv;
    e.tag = tag;
    e.ack = acc;
    e.en = m_en;
    e.sinfo = m_sinfo;
    e.spc = m_spc;
    e.save_valid = opv && op == 5'd16;
    e.pc_load = acc || (opv && op == 5'd29);
    e.pc_next = acc ? {20'h0, code, 4'h0} : ((opv && op == 5'd29) ? m_spc : 32'h0);
    sb_q.push_back(e);
    if (acc) begin
      m_spc = pc; m_sinfo = info; m_en = 1'b0;
    end else if (opv) begin
      case (op)
        5'd29, 5'd10: m_en = 1'b1;
        5'd11:        m_en = 1'b0;
        5'd17: begin m_sinfo = ra[15:0]; m_spc = rb; end
        default: ;
      endcase
    end
  endtask

  task automatic idle(string tag);
    drive(tag, 0, 0, 32'h0, 8'h0, 16'h0, 0, 5'd0, 32'h0, 32'h0);
  endtask

  task automatic do_op(string tag, logic [4:0] op, logic [31:0] ra, logic [31:0] rb);
    drive(tag, 0, 0, 32'h0, 8'h0, 16'h0, 1, op, ra, rb);
  endtask

  // monitor: compares just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (pc_load !== e.pc_load || pc_next !== e.pc_next || irq_ack !== e.ack ||
            irq_en !== e.en || save_valid !== e.save_valid ||
            saved_info !== e.sinfo || saved_pc !== e.spc) begin
          bad++;
          $display("FAIL %s: got load=%b next=%h ack=%b en=%b sv=%b info=%h spc=%h exp load=%b next=%h ack=%b en=%b sv=%b info=%h spc=%h",
                   e.tag, pc_load, pc_next, irq_ack, irq_en, save_valid, saved_info, saved_pc,
                   e.pc_load, e.pc_next, e.ack, e.en, e.save_valid, e.sinfo, e.spc);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R10 reset idle");
    do_op("R10 reset saved state", 5'd16, 32'h0, 32'h0);
    drive("R1 request while disabled", 1, 1, 32'h100, 8'h11, 16'h1111, 0, 5'd0, 0, 0);
    do_op("R7 enable", 5'd10, 0, 0);
    idle("R7 flag set");
    drive("R1 request outside fetch start", 0, 1, 32'h104, 8'h22, 16'h2222, 0, 5'd0, 0, 0);
    drive("R11 strobe beats request", 1, 1, 32'h108, 8'h33, 16'h3333, 1, 5'd10, 0, 0);
    drive("R1 R4 accepted", 1, 1, 32'h12345678, 8'hA5, 16'hBEEF, 0, 5'd0, 0, 0);
    idle("R3 R5 after entry");
    drive("R1 request while masked", 1, 1, 32'h200, 8'h44, 16'h4444, 0, 5'd0, 0, 0);
    do_op("R2 R8 save", 5'd16, 0, 0);
    do_op("R6 return", 5'd29, 0, 0);
    idle("R6 enabled after return");
    do_op("R7 disable", 5'd11, 0, 0);
    idle("R7 flag clear");
    do_op("R7 enable again", 5'd10, 0, 0);
    do_op("R9 restore", 5'd17, 32'hFFFF1357, 32'hCAFE0004);
    do_op("R9 R8 save after restore", 5'd16, 0, 0);
    do_op("R12 other opcode", 5'd5, 32'h1, 32'h2);
    do_op("R12 state unchanged", 5'd16, 0, 0);
    drive("R11 return with enabled request", 1, 1, 32'h300, 8'h55, 16'h5555, 1, 5'd29, 0, 0);
    drive("R11 R4 accepted next fetch", 1, 1, 32'h304, 8'hFF, 16'h0001, 0, 5'd0, 0, 0);
    idle("R5 pulse ended");
    do_op("R6 return to code", 5'd29, 0, 0);
    drive("R4 zero code vector", 1, 1, 32'h40, 8'h00, 16'h00C3, 0, 5'd0, 0, 0);
    do_op("R2 final save", 5'd16, 0, 0);
    idle("R3 final");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule